// File: doc/BRIEF.md
# Interrupt Aggregator with Message-Set Port

The block gathers 64 interrupt sources into one parent interrupt line. The lowest-numbered sources come from wires and behave as active-high levels. The remaining sources have no wire. A bus write to a dedicated set register raises one of them, and the write data gives the source number. All sources share one space of pending (cause) bits and one space of mask bits. A small register bus reaches both spaces.

Software unmasks the sources it services and waits for the parent line. It then scans the cause registers, register 0 first and each from bit 0 upward. It acknowledges a source by writing a one to that source's cause bit. Writing all ones to every cause and mask register returns the block to a quiet, fully masked state.

Top module: `irq_agg_top`

## Requirements
- R1: After reset, every cause bit is 0, every mask bit is 1, `irq_o` is 0 and `rd_data_o` is 0.
- R2: A read at byte address 0x00+4k returns cause register k, and a read at 0x20+4k returns mask register k (k = 0, 1). Source n sits in register n/32 at bit n%32. The data appears on `rd_data_o` in the cycle after the read request. `rd_data_o` is 0 in any cycle that follows no read. Reads of 0x30 and of unmapped addresses return 0.
- R3: A write to a mask register replaces all 32 bits. A mask bit of 1 keeps its source from reaching `irq_o`, and 0 lets it through.
- R4: Writing 1 to a cause bit clears it. Writing 0 leaves it unchanged. No other operation clears a cause bit.
- R5: Sources 0 to 20 follow `wired_irq_i`. The cause bit is set on every clock edge where the input is high. An acknowledge made while the input is still high leaves the bit set, because a set wins over a clear.
- R6: A write to address 0x30 whose full 32-bit data equals a number from 21 to 63 sets that source's cause bit.
- R7: A write to 0x30 whose data lies outside 21 to 63, including wired numbers and values of 64 and above, changes no cause bit.
- R8: `irq_o` is a register. It is 1 in the cycle after any cause bit was set while its mask bit was 0, and 0 otherwise.
- R9: A cause bit is latched regardless of its mask bit. Unmasking a source that is already pending raises `irq_o` without a new event.
- R10: Writing 0xFFFFFFFF to both cause registers and both mask registers clears every pending bit and masks every source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wired_irq_i | input | 21 | Level inputs for sources 0 to 20 |
| bus_valid_i | input | 1 | Bus request in this cycle |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, one cycle after the read request |
| irq_o | output | 1 | Aggregated parent interrupt |

## Verification
The hardest case is a clash between acknowledge and set on one bit. The single bus port cannot issue a message set and a clear in the same cycle. The clash therefore arises only between a held wired level and a cause write, so the stimulus acknowledges source 0 while its input is still high. Out-of-range message data is also driven with bits above bit 5 set, so that truncation to a 6-bit index would alias into a valid source. A long phase of mixed random traffic then lets a behavioural model compare both outputs on every clock.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int SRC_NUM_DEF   = 64;
  localparam int WIRED_NUM_DEF = 21;
  localparam int REG_W_DEF     = 32;
  localparam int ADDR_W_DEF    = 8;
  localparam int CAUSE_BASE    = 'h00;
  localparam int MASK_BASE     = 'h20;
  localparam int MSG_SET_OFF   = 'h30;
endpackage

// File: rtl/agg_reg_decode.sv
module agg_reg_decode
  import irq_agg_pkg::*;
#(
  parameter int SRC_NUM   = SRC_NUM_DEF,
  parameter int WIRED_NUM = WIRED_NUM_DEF,
  parameter int REG_W     = REG_W_DEF,
  parameter int ADDR_W    = ADDR_W_DEF,
  localparam int REG_NUM  = SRC_NUM / REG_W,
  localparam int IDX_W    = $clog2(SRC_NUM)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_valid_i,
  input  logic               bus_write_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [REG_W-1:0]   bus_wdata_i,
  input  logic [SRC_NUM-1:0] cause_i,
  input  logic [SRC_NUM-1:0] mask_i,
  output logic [SRC_NUM-1:0] cause_clr_o,
  output logic [REG_NUM-1:0] mask_we_o,
  output logic [SRC_NUM-1:0] msg_set_o,
  output logic [REG_W-1:0]   rd_data_o
);
  localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(MSG_SET_OFF);
  localparam logic [SRC_NUM-1:0] WIRED_BITS = SRC_NUM'((64'(1) << WIRED_NUM) - 64'(1));

  logic wr_en, rd_en;
  assign wr_en = bus_valid_i & bus_write_i;
  assign rd_en = bus_valid_i & ~bus_write_i;

  for (genvar k = 0; k < REG_NUM; k++) begin : g_reg
    localparam logic [ADDR_W-1:0] C_ADDR = ADDR_W'(CAUSE_BASE + 4 * k);
    localparam logic [ADDR_W-1:0] M_ADDR = ADDR_W'(MASK_BASE + 4 * k);
    logic cause_hit;
    assign cause_hit = wr_en && (bus_addr_i == C_ADDR);
    assign cause_clr_o[k*REG_W +: REG_W] = cause_hit ? bus_wdata_i : '0;
    assign mask_we_o[k] = wr_en && (bus_addr_i == M_ADDR);
  end

  logic msg_hit, msg_in_range;
  assign msg_hit      = wr_en && (bus_addr_i == SET_ADDR);
  assign msg_in_range = (bus_wdata_i >= REG_W'(WIRED_NUM)) && (bus_wdata_i < REG_W'(SRC_NUM));
  assign msg_set_o    = (msg_hit && msg_in_range)
                      ? (SRC_NUM'(1) << bus_wdata_i[IDX_W-1:0]) : '0;

  logic [REG_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    for (int k = 0; k < REG_NUM; k++) begin
      if (bus_addr_i == ADDR_W'(CAUSE_BASE + 4 * k)) rd_next = cause_i[k*REG_W +: REG_W];
      if (bus_addr_i == ADDR_W'(MASK_BASE + 4 * k))  rd_next = mask_i[k*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rd_data_o <= '0;
    else if (rd_en) rd_data_o <= rd_next;
    else            rd_data_o <= '0;
  end

  assert_rd_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> (rd_data_o == '0));
  assert_msg_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(msg_set_o));
  assert_msg_no_wired_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_set_o & WIRED_BITS) == '0);
endmodule

// File: rtl/agg_cause_bank.sv
module agg_cause_bank
  import irq_agg_pkg::*;
#(
  parameter int SRC_NUM   = SRC_NUM_DEF,
  parameter int WIRED_NUM = WIRED_NUM_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [WIRED_NUM-1:0] wired_i,
  input  logic [SRC_NUM-1:0]   msg_set_i,
  input  logic [SRC_NUM-1:0]   clr_i,
  output logic [SRC_NUM-1:0]   cause_o
);
  for (genvar i = 0; i < SRC_NUM; i++) begin : g_src
    logic set_now;
    if (i < WIRED_NUM) begin : g_wired
      assign set_now = wired_i[i] | msg_set_i[i];
    end else begin : g_msg
      assign set_now = msg_set_i[i];
    end

    // set beats clear on the same edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cause_o[i] <= 1'b0;
      else         cause_o[i] <= (cause_o[i] & ~clr_i[i]) | set_now;
    end

    assert_ack_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_now) |=> !cause_o[i]);
    assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[i] && !set_now) |=> $stable(cause_o[i]));
    assert_set_lands_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      msg_set_i[i] |=> cause_o[i]);
    if (i < WIRED_NUM) begin : g_chk
      assert_level_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wired_i[i] |=> cause_o[i]);
    end
  end
endmodule

// File: rtl/agg_mask_bank.sv
module agg_mask_bank
  import irq_agg_pkg::*;
#(
  parameter int SRC_NUM  = SRC_NUM_DEF,
  parameter int REG_W    = REG_W_DEF,
  localparam int REG_NUM = SRC_NUM / REG_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [REG_NUM-1:0] we_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [SRC_NUM-1:0] mask_o
);
  for (genvar k = 0; k < REG_NUM; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mask_o[k*REG_W +: REG_W] <= '1;
      else if (we_i[k]) mask_o[k*REG_W +: REG_W] <= wdata_i;
    end

    assert_mask_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i[k] |=> (mask_o[k*REG_W +: REG_W] == $past(wdata_i)));
  end
endmodule

// File: rtl/agg_parent.sv
module agg_parent
  import irq_agg_pkg::*;
#(
  parameter int SRC_NUM = SRC_NUM_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SRC_NUM-1:0] cause_i,
  input  logic [SRC_NUM-1:0] mask_i,
  output logic               irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(cause_i & ~mask_i);
  end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int SRC_NUM   = SRC_NUM_DEF,
  parameter int WIRED_NUM = WIRED_NUM_DEF,
  parameter int REG_W     = REG_W_DEF,
  parameter int ADDR_W    = ADDR_W_DEF,
  localparam int REG_NUM  = SRC_NUM / REG_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [WIRED_NUM-1:0] wired_irq_i,
  input  logic                 bus_valid_i,
  input  logic                 bus_write_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [REG_W-1:0]     bus_wdata_i,
  output logic [REG_W-1:0]     rd_data_o,
  output logic                 irq_o
);
  logic [SRC_NUM-1:0] cause_q, mask_q, cause_clr, msg_set;
  logic [REG_NUM-1:0] mask_we;

  agg_reg_decode #(
    .SRC_NUM(SRC_NUM), .WIRED_NUM(WIRED_NUM), .REG_W(REG_W), .ADDR_W(ADDR_W)
  ) u_decode (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .cause_i(cause_q), .mask_i(mask_q),
    .cause_clr_o(cause_clr), .mask_we_o(mask_we), .msg_set_o(msg_set),
    .rd_data_o(rd_data_o)
  );

  agg_cause_bank #(.SRC_NUM(SRC_NUM), .WIRED_NUM(WIRED_NUM)) u_cause (
    .clk_i(clk_i), .rst_ni(rst_ni), .wired_i(wired_irq_i),
    .msg_set_i(msg_set), .clr_i(cause_clr), .cause_o(cause_q)
  );

  agg_mask_bank #(.SRC_NUM(SRC_NUM), .REG_W(REG_W)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(mask_we),
    .wdata_i(bus_wdata_i), .mask_o(mask_q)
  );

  agg_parent #(.SRC_NUM(SRC_NUM)) u_parent (
    .clk_i(clk_i), .rst_ni(rst_ni), .cause_i(cause_q), .mask_i(mask_q), .irq_o(irq_o)
  );

  assert_all_masked_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |=> !irq_o);
  assert_pending_raises_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause_q & ~mask_q) != '0) |=> irq_o);
endmodule

// File: tb/tb_irq_agg_top.sv
module tb_irq_agg_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] wired = '0;
  logic        valid = 1'b0, write = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  irq_agg_top dut (
    .clk_i(clk), .rst_ni(rst_n), .wired_irq_i(wired),
    .bus_valid_i(valid), .bus_write_i(write), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [63:0] m_cause, m_mask;
  logic [31:0] m_rd;
  logic        m_irq;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_cause[31:0];
      8'h04: return m_cause[63:32];
      8'h20: return m_mask[31:0];
      8'h24: return m_mask[63:32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cause = '0; m_mask = '1; m_rd = '0; m_irq = 1'b0;
    end else begin
      logic [63:0] c, s;
      m_irq = |(m_cause & ~m_mask);
      m_rd  = (valid && !write) ? m_read(addr) : 32'h0;
      c = '0; s = '0;
      for (int i = 0; i < 21; i++) if (wired[i]) s[i] = 1'b1;
      if (valid && write) begin
        if (addr == 8'h00) c[31:0]  = wdata;
        if (addr == 8'h04) c[63:32] = wdata;
        if (addr == 8'h20) m_mask[31:0]  = wdata;
        if (addr == 8'h24) m_mask[63:32] = wdata;
        if (addr == 8'h30 && wdata >= 21 && wdata <= 63) s[wdata] = 1'b1;
      end
      m_cause = (m_cause & ~c) | s;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp += 2;
      if (rd_data !== m_rd) begin
        n_bad++;
        $display("FAIL %s rd_data_o actual=%h expected=%h t=%0t", cur_req, rd_data, m_rd, $time);
      end
      if (irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s irq_o actual=%b expected=%b t=%0t", cur_req, irq, m_irq, $time);
      end
    end
  end

  task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); valid = 1'b1; write = w; addr = a; wdata = d;
    @(negedge clk); valid = 1'b0; write = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_all();
    bus(0, 8'h00, 0); bus(0, 8'h04, 0); bus(0, 8'h20, 0); bus(0, 8'h24, 0);
  endtask

  initial begin
    cur_req = "R1";
    idle(3); rst_n = 1'b1; idle(2);
    read_all();

    cur_req = "R2";
    bus(0, 8'h30, 0); bus(0, 8'h10, 0); bus(0, 8'hFC, 0); bus(0, 8'h24, 0);

    cur_req = "R3";
    bus(1, 8'h20, 32'hFFFF_FFFE); bus(0, 8'h20, 0); idle(2);

    cur_req = "R5";
    @(negedge clk); wired[0] = 1'b1; wired[3] = 1'b1; idle(3);
    bus(0, 8'h00, 0);
    bus(1, 8'h00, 32'h1);        // ack while level still high
    bus(0, 8'h00, 0); idle(2);
    @(negedge clk); wired[0] = 1'b0; wired[3] = 1'b0;
    bus(1, 8'h00, 32'h1); bus(0, 8'h00, 0); idle(2);

    cur_req = "R4";
    bus(1, 8'h00, 32'h0); bus(0, 8'h00, 0);
    bus(1, 8'h00, 32'h8); bus(0, 8'h00, 0); idle(2);

    cur_req = "R6";
    bus(1, 8'h30, 21); bus(1, 8'h30, 63); bus(1, 8'h30, 40);
    bus(0, 8'h00, 0); bus(0, 8'h04, 0); idle(2);

    cur_req = "R9";
    bus(1, 8'h24, 32'h0); idle(3);   // pending sources now unmasked
    bus(1, 8'h20, 32'h0); idle(2);

    cur_req = "R7";
    bus(1, 8'h04, 32'hFFFF_FFFF); bus(1, 8'h00, 32'hFFFF_FFFF); idle(2);
    bus(1, 8'h30, 64); bus(1, 8'h30, 5); bus(1, 8'h30, 20);
    bus(1, 8'h30, 32'h0000_011E); bus(1, 8'h30, 32'h8000_0016);
    bus(0, 8'h00, 0); bus(0, 8'h04, 0); idle(2);

    cur_req = "R8";
    bus(1, 8'h30, 50); idle(3);
    bus(1, 8'h24, 32'hFFFF_FFFF); idle(2);
    bus(1, 8'h24, 32'h0); idle(2);
    bus(1, 8'h04, 32'h0004_0000); idle(3);

    cur_req = "R10";
    @(negedge clk); wired = 21'h00_0F0F; idle(2);
    @(negedge clk); wired = '0;
    bus(1, 8'h30, 33); bus(1, 8'h30, 22);
    bus(1, 8'h00, 32'hFFFF_FFFF); bus(1, 8'h04, 32'hFFFF_FFFF);
    bus(1, 8'h20, 32'hFFFF_FFFF); bus(1, 8'h24, 32'hFFFF_FFFF);
    read_all(); idle(2);

    cur_req = "R5 R6 R4 mixed traffic";
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      if (($urandom % 8) == 0) wired = 21'($urandom);
      valid = ($urandom % 3) != 0;
      write = $urandom % 2;
      case ($urandom % 7)
        0: addr = 8'h00; 1: addr = 8'h04; 2: addr = 8'h20;
        3: addr = 8'h24; 4, 5: addr = 8'h30; default: addr = 8'($urandom);
      endcase
      wdata = (addr == 8'h30) ? ($urandom % 80) : $urandom;
    end
    @(negedge clk); valid = 1'b0; wired = '0;
    idle(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule